// File: doc/BRIEF.md
# Fractional Phase to DTC Delay Predictor with Adaptive Gain

This block is the reference-rate digital core that steers a digital-to-time converter (DTC) in a fractional-N all-digital PLL. On every accepted reference cycle it does three things. It adds the low-frequency modulation sample to the frequency command word. It accumulates the fractional part of that word modulo one and carries any overflow into an integer reference phase. It scales the new fraction by a learned DTC gain to produce the delay code for a 64-step delay line.

The gain is the ratio of the divided-clock period to one DTC step, held as unsigned fixed point with 10 fraction bits. A sign-sign LMS loop keeps it tracked. The sign of the signed fine phase error from the TDC selects whether a scaled copy of the fraction that produced that error is added to the gain or subtracted from it. Calibration can be frozen, and the gain restarts from a value given on a pin.

Input samples arrive as a valid-qualified stream with no back-pressure. The block accepts every cycle in which `in_vld` is high, and it cannot stall. Each accepted sample produces exactly one result, marked by `out_vld`, one clock later. A downstream consumer must take that result in the cycle it appears.

Top module: `dtc_phase_predictor`

## Requirements
- R1: While `rst_n` is low, the fraction and `ref_phase` are 0, `dtc_code` is 0, `out_vld` is 0 and `gain_est` equals `gain_init`.
- R2: The command word is `{fcw_int, fcw_frac}`, 24 bits with the low 16 bits as fraction. `mod_lf` is sign-extended and added to it modulo 2^24 before accumulation.
- R3: On an accepted cycle the 16-bit fraction becomes (fraction + word[15:0]) mod 2^16. `ref_phase` becomes (ref_phase + word[23:16] + carry) mod 256, where carry is 1 when the fraction sum reached 2^16.
- R4: On an accepted cycle `dtc_code` becomes floor(new_fraction * gain / 2^26). Here gain is the value of `gain_est` before that cycle's update, and the result is saturated at 63.
- R5: With `cal_en` high on an accepted cycle, `fine_err` (5-bit two's complement) selects the update. A positive value adds (prev_fraction >> 8) to the gain, a negative value subtracts it, and zero leaves the gain unchanged. prev_fraction is the fraction before this cycle's update, the one whose code is being measured.
- R6: The gain saturates at 0 and at 2^17-1 and never wraps.
- R7: With `cal_en` low, `gain_est` holds its value.
- R8: A cycle with `in_vld` low changes neither the fraction, `ref_phase`, `dtc_code` nor `gain_est`.
- R9: `out_vld` is high exactly in the cycle after an accepted cycle. All results of that sample are on the outputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_init | input | 17 | Nominal gain loaded at reset, Q7.10 |
| cal_en | input | 1 | Enables the LMS gain update |
| in_vld | input | 1 | Input sample valid, always accepted |
| fcw_int | input | 8 | Integer part of the command word |
| fcw_frac | input | 16 | Fractional part of the command word |
| mod_lf | input | 16 | Signed low-frequency modulation sample |
| fine_err | input | 5 | Signed fine phase error from the TDC |
| out_vld | output | 1 | Result valid, one cycle after acceptance |
| dtc_code | output | 6 | Delay code for the 64-step DTC |
| ref_phase | output | 8 | Integer reference phase |
| gain_est | output | 17 | Current gain estimate, Q7.10 |

## Verification
Every result of a sample accepted at a rising edge is due exactly one edge later. `dtc_code`, `ref_phase`, `gain_est` and `out_vld` all come from registers loaded at the accepting edge, and there is no further pipeline. The bench therefore drives each sample on a falling edge and compares all four outputs at the next falling edge against a model stepped once per sample. Idle cycles are checked the same way, to show that nothing moved. Corner cases use gains chosen to force code saturation and both gain clamps.

// File: rtl/dtc_pp_pkg.sv
package dtc_pp_pkg;
  typedef enum logic [1:0] {
    ERR_ZERO = 2'd0,
    ERR_POS  = 2'd1,
    ERR_NEG  = 2'd2
  } err_dir_e;

  function automatic err_dir_e err_direction(input logic sign_bit, input logic nonzero);
    if (!nonzero)     return ERR_ZERO;
    else if (sign_bit) return ERR_NEG;
    else              return ERR_POS;
  endfunction
endpackage

// File: rtl/dtc_frac_accum.sv
module dtc_frac_accum #(
  parameter int FRAC_W = 16,
  parameter int INT_W  = 8,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [INT_W-1:0]  fcw_int,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [MOD_W-1:0]  mod_lf,
  output logic [FRAC_W-1:0] frac_q,
  output logic [FRAC_W-1:0] frac_n,
  output logic [INT_W-1:0]  phase_q
);
  localparam int WORD_W = INT_W + FRAC_W;

  logic [WORD_W-1:0] mod_ext;
  logic [WORD_W-1:0] word;
  logic [FRAC_W:0]   fsum;
  logic              carry;
  logic [INT_W-1:0]  word_int;
  logic [INT_W-1:0]  phase_n;

  assign mod_ext  = {{(WORD_W-MOD_W){mod_lf[MOD_W-1]}}, mod_lf};
  assign word     = {fcw_int, fcw_frac} + mod_ext;
  assign word_int = word[WORD_W-1:FRAC_W];
  assign fsum     = {1'b0, frac_q} + {1'b0, word[FRAC_W-1:0]};
  assign frac_n   = fsum[FRAC_W-1:0];
  assign carry    = fsum[FRAC_W];
  assign phase_n  = phase_q + word_int + INT_W'(carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= '0;
      phase_q <= '0;
    end else if (in_vld) begin
      frac_q  <= frac_n;
      phase_q <= phase_n;
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(frac_q) && $stable(phase_q)));

  // R3
  carry_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && carry) |=> (phase_q == INT_W'($past(phase_q) + $past(word_int) + 1'b1)));
endmodule

// File: rtl/dtc_code_map.sv
module dtc_code_map #(
  parameter int FRAC_W    = 16,
  parameter int GAIN_W    = 17,
  parameter int GAIN_FRAC = 10,
  parameter int CODE_W    = 6
) (
  input  logic [FRAC_W-1:0] frac,
  input  logic [GAIN_W-1:0] gain,
  output logic [CODE_W-1:0] code
);
  localparam int PROD_W  = FRAC_W + GAIN_W;
  localparam int SHIFT   = FRAC_W + GAIN_FRAC;
  localparam int WHOLE_W = PROD_W - SHIFT;

  logic [PROD_W-1:0]  prod;
  logic [WHOLE_W-1:0] whole;

  assign prod  = PROD_W'(frac) * PROD_W'(gain);
  assign whole = prod[PROD_W-1:SHIFT];

  generate
    if (WHOLE_W > CODE_W) begin : g_sat
      localparam logic [WHOLE_W-1:0] CODE_MAX = WHOLE_W'({CODE_W{1'b1}});
      always_comb begin
        if (whole > CODE_MAX) code = {CODE_W{1'b1}};
        else                  code = whole[CODE_W-1:0];
      end
    end else begin : g_pass
      assign code = CODE_W'(whole);
    end
  endgenerate
endmodule

// File: rtl/dtc_gain_lms.sv
module dtc_gain_lms
  import dtc_pp_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int GAIN_W   = 17,
  parameter int ERR_W    = 5,
  parameter int MU_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              cal_en,
  input  logic [ERR_W-1:0]  fine_err,
  input  logic [FRAC_W-1:0] frac_prev,
  input  logic [GAIN_W-1:0] gain_init,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int EXT_W = ((FRAC_W > GAIN_W) ? FRAC_W : GAIN_W) + 1;
  localparam logic [EXT_W-1:0] GMAX = EXT_W'({GAIN_W{1'b1}});

  err_dir_e          dir;
  logic [EXT_W-1:0]  step;
  logic [EXT_W-1:0]  gext;
  logic [EXT_W-1:0]  gsum;
  logic [GAIN_W-1:0] gain_n;

  assign dir  = err_direction(fine_err[ERR_W-1], |fine_err);
  assign step = EXT_W'(frac_prev >> MU_SHIFT);
  assign gext = EXT_W'(gain_q);
  assign gsum = gext + step;

  always_comb begin
    gain_n = gain_q;
    unique case (dir)
      ERR_POS: gain_n = (gsum > GMAX) ? GMAX[GAIN_W-1:0] : gsum[GAIN_W-1:0];
      ERR_NEG: gain_n = (step > gext) ? '0 : GAIN_W'(gext - step);
      default: gain_n = gain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gain_q <= gain_init;
    else if (in_vld && cal_en) gain_q <= gain_n;
  end

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> $stable(gain_q));

  // R5
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cal_en && fine_err == '0) |=> $stable(gain_q));

  // R6
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cal_en && !fine_err[ERR_W-1]) |=> (gain_q >= $past(gain_q)));

  // R6
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cal_en && fine_err[ERR_W-1]) |=> (gain_q <= $past(gain_q)));
endmodule

// File: rtl/dtc_phase_predictor.sv
module dtc_phase_predictor #(
  parameter int FRAC_W    = 16,
  parameter int INT_W     = 8,
  parameter int MOD_W     = 16,
  parameter int GAIN_W    = 17,
  parameter int GAIN_FRAC = 10,
  parameter int CODE_W    = 6,
  parameter int ERR_W     = 5,
  parameter int MU_SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] gain_init,
  input  logic              cal_en,
  input  logic              in_vld,
  input  logic [INT_W-1:0]  fcw_int,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [MOD_W-1:0]  mod_lf,
  input  logic [ERR_W-1:0]  fine_err,
  output logic              out_vld,
  output logic [CODE_W-1:0] dtc_code,
  output logic [INT_W-1:0]  ref_phase,
  output logic [GAIN_W-1:0] gain_est
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_n;
  logic [CODE_W-1:0] code_n;
  logic [CODE_W-1:0] code_q;
  logic              vld_q;

  dtc_frac_accum #(.FRAC_W(FRAC_W), .INT_W(INT_W), .MOD_W(MOD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .fcw_int(fcw_int), .fcw_frac(fcw_frac), .mod_lf(mod_lf),
    .frac_q(frac_q), .frac_n(frac_n), .phase_q(ref_phase)
  );

  dtc_code_map #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
                 .CODE_W(CODE_W)) u_map (
    .frac(frac_n), .gain(gain_est), .code(code_n)
  );

  dtc_gain_lms #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .ERR_W(ERR_W),
                 .MU_SHIFT(MU_SHIFT)) u_lms (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cal_en(cal_en),
    .fine_err(fine_err), .frac_prev(frac_q), .gain_init(gain_init),
    .gain_q(gain_est)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) code_q <= code_n;
    end
  end

  assign dtc_code = code_q;
  assign out_vld  = vld_q;

  // R9
  out_vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R9
  out_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R4
  zero_gain_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && gain_est == '0) |=> (dtc_code == '0));

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(dtc_code));
endmodule

// File: tb/sim_dtc_phase_predictor.sv
module sim_dtc_phase_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] gain_init = 17'd59392;
  logic        cal_en = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  fcw_int = '0;
  logic [15:0] fcw_frac = '0;
  logic [15:0] mod_lf = '0;
  logic [4:0]  fine_err = '0;
  logic        out_vld;
  logic [5:0]  dtc_code;
  logic [7:0]  ref_phase;
  logic [16:0] gain_est;

  int n_run = 0;
  int n_fail = 0;

  longint m_frac, m_phase, m_gain;

  always #2.5 clk = ~clk;

  dtc_phase_predictor u0 (
    .clk(clk), .rst_n(rst_n), .gain_init(gain_init), .cal_en(cal_en),
    .in_vld(in_vld), .fcw_int(fcw_int), .fcw_frac(fcw_frac), .mod_lf(mod_lf),
    .fine_err(fine_err), .out_vld(out_vld), .dtc_code(dtc_code),
    .ref_phase(ref_phase), .gain_est(gain_est)
  );

  // {vld, cal, int[8], frac[16], mod[16], err[5]}
  localparam logic [46:0] VEC [10] = '{
    {1'b1, 1'b0, 8'd1, 16'h4000, 16'h0000, 5'd3},
    {1'b1, 1'b1, 8'd1, 16'h4000, 16'h0000, 5'd3},
    {1'b1, 1'b1, 8'd1, 16'hC000, 16'h0000, 5'h1E},
    {1'b1, 1'b1, 8'd2, 16'h8000, 16'h0100, 5'd0},
    {1'b1, 1'b0, 8'd0, 16'h9000, 16'hF000, 5'd5},
    {1'b0, 1'b1, 8'd3, 16'h1234, 16'h0000, 5'd7},
    {1'b1, 1'b1, 8'd0, 16'h0000, 16'h0000, 5'h18},
    {1'b1, 1'b1, 8'd1, 16'hFFFF, 16'h0001, 5'd1},
    {1'b1, 1'b1, 8'd0, 16'h7000, 16'h8000, 5'h1F},
    {1'b1, 1'b0, 8'd5, 16'h2000, 16'h0000, 5'h1C}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [16:0] g);
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; cal_en = 1'b0; gain_init = g;
    @(negedge clk);
    check("R1 ref_phase", ref_phase, 0);
    check("R1 dtc_code", dtc_code, 0);
    check("R1 out_vld", out_vld, 0);
    check("R1 gain_est", gain_est, g);
    rst_n = 1'b1;
    m_frac = 0; m_phase = 0; m_gain = g;
  endtask

  task automatic step(input logic [46:0] v);
    longint word, sum, carry, wi, wf, d, g_old, mexp;
    logic   vld, cal;
    logic [4:0] err;
    vld = v[46]; cal = v[45]; err = v[4:0];
    in_vld = vld; cal_en = cal;
    fcw_int = v[44:37]; fcw_frac = v[36:21]; mod_lf = v[20:5]; fine_err = err;
    // model, R2 .. R6
    mexp = {{8{v[20]}}, v[20:5]};
    word = (((longint'(v[44:37]) << 16) | longint'(v[36:21])) + mexp) & 64'hFFFFFF;
    wf = word & 64'hFFFF;
    wi = (word >> 16) & 64'hFF;
    g_old = m_gain;
    if (vld) begin
      if (cal && err != 0) begin
        d = m_frac >> 8;
        if (!err[4]) m_gain = (m_gain + d > 131071) ? 131071 : m_gain + d;
        else         m_gain = (d > m_gain) ? 0 : m_gain - d;
      end
      sum = m_frac + wf;
      carry = sum >> 16;
      m_frac = sum & 64'hFFFF;
      m_phase = (m_phase + wi + carry) & 64'hFF;
    end
    @(negedge clk);
    check(vld ? "R9 out_vld" : "R8 out_vld", out_vld, vld);
    check(vld ? "R3 ref_phase" : "R8 ref_phase", ref_phase, m_phase);
    check(cal ? "R5 gain_est" : "R7 gain_est", gain_est, m_gain);
    if (vld) begin
      sum = (m_frac * g_old) >> 26;
      check("R4 dtc_code", dtc_code, (sum > 63) ? 63 : sum);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] hold_code;
    do_reset(17'd59392);
    // vector table: R2 modulation, R3 carry, R5 signs, R7 freeze, R8 idle
    for (int i = 0; i < 10; i++) step(VEC[i]);
    // R8: idle cycle keeps the code
    hold_code = dtc_code;
    step({1'b0, 1'b1, 8'd9, 16'hABCD, 16'h1111, 5'd3});
    check("R8 dtc_code", dtc_code, hold_code);
    // R4: code saturation at 63
    do_reset(17'd102400);
    step({1'b1, 1'b0, 8'd0, 16'h8000, 16'h0000, 5'd0});
    step({1'b1, 1'b0, 8'd0, 16'h4000, 16'h0000, 5'd0});
    check("R4 saturated code", dtc_code, 63);
    // R6: upper clamp
    do_reset(17'd131000);
    step({1'b1, 1'b0, 8'd0, 16'hFF00, 16'h0000, 5'd0});
    step({1'b1, 1'b1, 8'd0, 16'h0000, 16'h0000, 5'd1});
    check("R6 upper clamp", gain_est, 131071);
    // R6: lower clamp
    do_reset(17'd10);
    step({1'b1, 1'b0, 8'd0, 16'hFF00, 16'h0000, 5'd0});
    step({1'b1, 1'b1, 8'd0, 16'h0000, 16'h0000, 5'h1F});
    check("R6 lower clamp", gain_est, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule